// File: doc/BRIEF.md
# Strided Loop Address Generator with Multiply-Accumulate

This block runs a counted hardware loop on its own, so the datapath attached to it needs no control state machine. Software sets a start address, a signed step, a trip count, a scale constant and an access mode, then pulses a start strobe. The block walks the array one element per iteration. It issues requests to a single memory port with a valid/ready handshake and multiplies each fetched element by the constant. The products are summed in a 32-bit accumulator.

Two access orders are supported. In the read-only order each iteration makes one read. In the read-then-write order each iteration reads an element and then writes the scaled element back to the same address. Loop counting and the exit test sit in a dedicated counter. The address moves only when a request is accepted. When the count runs out, a one-cycle done pulse hands control back to software, and the accumulator keeps its result until the next start.

Top module: `loop_agu_top`

## Requirements
- R1: After reset, mem_req_valid, done and busy are low and acc_out is zero.
- R2: The address of iteration k (counting from 0) is cfg_base plus k times the sign-extended cfg_stride, taken modulo 2^32.
- R3: With cfg_mode = 0 (read-only), each iteration issues exactly one read (mem_req_write = 0), for cfg_count requests in total.
- R4: With cfg_mode = 1 (read-then-write), each iteration issues a read and then a write (mem_req_write = 1) to the same address. The write data is the low 32 bits of the element read times cfg_coef.
- R5: While mem_req_valid is high and mem_req_ready is low, the request address and direction hold. The loop advances only on an accepted request.
- R6: acc_out equals the sum, modulo 2^32, of element times cfg_coef over all iterations. It is cleared at start and holds its value after done until the next start.
- R7: done is a single-cycle pulse in the cycle after the last request is accepted. busy and mem_req_valid are low while done is high.
- R8: A start with cfg_count = 0 raises done in the cycle after start and issues no memory request.
- R9: The configuration is sampled at start. Later changes to the cfg inputs, and start pulses while busy, have no effect on the running loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 32 | First element address |
| cfg_stride | input | 16 | Signed address step per iteration |
| cfg_count | input | 16 | Number of iterations |
| cfg_mode | input | 1 | 0 read-only, 1 read then write |
| cfg_coef | input | 32 | Scale constant for each element |
| start | input | 1 | Start strobe, sampled when idle |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Request address |
| mem_req_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle a read is accepted |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 32 | Accumulated result |

## Verification
The assertions assume that read data is valid in the same cycle a read is accepted. They also assume that start is a one-cycle strobe that software does not raise in the done cycle. The bench memory meets the first assumption with a combinational model that computes each element from its address. The bench raises start only from idle, except for the deliberate start pulse that tests the R9 rule while a loop is running. Ready is drawn at random from a seeded generator at several acceptance rates, so stalls are exercised without breaking the handshake rules.

// File: rtl/lagu_pkg.sv
package lagu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_e;

    typedef enum logic {
        MODE_RD_ONLY = 1'b0,
        MODE_RD_WR   = 1'b1
    } access_mode_e;
endpackage

// File: rtl/lagu_addr_stepper.sv
module lagu_addr_stepper #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] stride,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam int XW = AW - SW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] incr;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.addr = base;
            s_d.incr = {{XW{stride[SW-1]}}, stride};
        end else if (step) begin
            s_d.addr = s_q.addr + s_q.incr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;
endmodule

// File: rtl/lagu_iter_counter.sv
module lagu_iter_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] count,
    input  logic          step,
    output logic          last
);
    typedef struct packed {
        logic [CW-1:0] remaining;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load)      s_d.remaining = count;
        else if (step) s_d.remaining = s_q.remaining - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign last = (s_q.remaining == CW'(1));
endmodule

// File: rtl/lagu_mac.sv
module lagu_mac #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [DW-1:0] elem,
    input  logic [DW-1:0] coef,
    output logic [DW-1:0] prod,
    output logic [DW-1:0] acc
);
    typedef struct packed {
        logic [DW-1:0] acc;
    } st_t;

    st_t s_d, s_q;

    assign prod = elem * coef;

    always_comb begin
        s_d = s_q;
        if (clear)   s_d.acc = '0;
        else if (en) s_d.acc = s_q.acc + prod;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc = s_q.acc;
endmodule

// File: rtl/loop_agu_top.sv
module loop_agu_top
    import lagu_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [SW-1:0] cfg_stride,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_mode,
    input  logic [DW-1:0] cfg_coef,
    input  logic          start,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] acc_out
);
    typedef struct packed {
        seq_state_e    state;
        access_mode_e  mode;
        logic [DW-1:0] coef;
        logic [DW-1:0] wdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          ld;
    logic          adv;
    logic          mac_en;
    logic          last_it;
    logic [DW-1:0] prod;
    logic          accept;

    assign accept = mem_req_valid && mem_req_ready;

    always_comb begin
        c_d    = c_q;
        ld     = 1'b0;
        adv    = 1'b0;
        mac_en = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    ld        = 1'b1;
                    c_d.mode  = access_mode_e'(cfg_mode);
                    c_d.coef  = cfg_coef;
                    c_d.state = (cfg_count == '0) ? ST_FIN : ST_RD;
                end
            end
            ST_RD: begin
                if (accept) begin
                    mac_en    = 1'b1;
                    c_d.wdata = prod;
                    if (c_q.mode == MODE_RD_WR) begin
                        c_d.state = ST_WR;
                    end else begin
                        adv       = 1'b1;
                        c_d.state = last_it ? ST_FIN : ST_RD;
                    end
                end
            end
            ST_WR: begin
                if (accept) begin
                    adv       = 1'b1;
                    c_d.state = last_it ? ST_FIN : ST_RD;
                end
            end
            ST_FIN: begin
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, mode: MODE_RD_ONLY, coef: '0, wdata: '0};
        else        c_q <= c_d;
    end

    lagu_addr_stepper #(.AW(AW), .SW(SW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld),
        .base  (cfg_base),
        .stride(cfg_stride),
        .step  (adv),
        .addr  (mem_req_addr)
    );

    lagu_iter_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ld),
        .count (cfg_count),
        .step  (adv),
        .last  (last_it)
    );

    lagu_mac #(.DW(DW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ld),
        .en    (mac_en),
        .elem  (mem_rdata),
        .coef  (c_q.coef),
        .prod  (prod),
        .acc   (acc_out)
    );

    assign mem_req_valid = (c_q.state == ST_RD) || (c_q.state == ST_WR);
    assign mem_req_write = (c_q.state == ST_WR);
    assign mem_req_wdata = c_q.wdata;
    assign busy          = mem_req_valid;
    assign done          = (c_q.state == ST_FIN);
endmodule

// File: rtl/lagu_chk.sv
module lagu_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_write,
    input logic [AW-1:0] mem_req_addr,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] acc_out
);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    p_wr_then_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_req_write) |=> !mem_req_write);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req_valid));

    p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(acc_out));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind loop_agu_top lagu_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write),
    .mem_req_addr (mem_req_addr),
    .busy         (busy),
    .done         (done),
    .acc_out      (acc_out)
);

// File: tb/sim_loop_agu_top.sv
`timescale 1ns/1ps
module sim_loop_agu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_stride = '0;
    logic [15:0] cfg_count = '0;
    logic        cfg_mode = 1'b0;
    logic [31:0] cfg_coef = '0;
    logic        start = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic [31:0] mem_rdata;
    logic        busy;
    logic        done;
    logic [31:0] acc_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] elem_of(input logic [31:0] a);
        return (a * 32'h0001_0193) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] sext(input logic [15:0] s);
        return {{16{s[15]}}, s};
    endfunction

    function automatic logic [31:0] exp_acc(input logic [31:0] base, input logic [15:0] stride,
                                            input logic [15:0] cnt, input logic [31:0] coef);
        logic [31:0] sum = '0;
        for (int k = 0; k < int'(cnt); k++)
            sum = sum + elem_of(base + 32'(k) * sext(stride)) * coef;
        return sum;
    endfunction

    assign mem_rdata = elem_of(mem_req_addr);

    loop_agu_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
        .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_coef(cfg_coef), .start(start),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .acc_out(acc_out)
    );

    task automatic check(input string req, input bit ok, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_loop(input logic [31:0] base, input logic [15:0] stride,
                            input logic [15:0] cnt, input logic md, input logic [31:0] coef,
                            input int rdy_pct, input bit disturb);
        int n_acc = 0;
        int exp_n;
        int seq_bad = 0;
        int stall_bad = 0;
        int done_cyc = -1;
        int last_acc = -1;
        int cyc = 0;
        int it;
        bit ph;
        bit prev_stall = 0;
        logic [31:0] prev_addr = '0;
        logic [31:0] a_exp;
        logic [31:0] ea;
        logic [31:0] hold;
        exp_n = int'(cnt) * (md ? 2 : 1);
        ea = exp_acc(base, stride, cnt, coef);
        @(negedge clk);
        cfg_base = base; cfg_stride = stride; cfg_count = cnt; cfg_mode = md; cfg_coef = coef;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            cfg_base = ~base; cfg_stride = stride + 16'd3; cfg_count = 16'd2;
            cfg_mode = ~md; cfg_coef = coef + 32'd7;
        end
        while (done_cyc < 0 && cyc < 4000) begin
            mem_req_ready = (($urandom % 100) < rdy_pct);
            start = disturb && (cyc == 2);
            #1;
            if (prev_stall && (mem_req_addr !== prev_addr)) stall_bad++;
            if (done) done_cyc = cyc;
            if (mem_req_valid && mem_req_ready) begin
                it = md ? n_acc / 2 : n_acc;
                ph = md ? n_acc[0] : 1'b0;
                a_exp = base + 32'(it) * sext(stride);
                if (n_acc >= exp_n) seq_bad++;
                else if (mem_req_addr !== a_exp || mem_req_write !== ph) seq_bad++;
                else if (ph && mem_req_wdata !== elem_of(a_exp) * coef) seq_bad++;
                n_acc++;
                last_acc = cyc;
            end
            prev_stall = mem_req_valid && !mem_req_ready;
            prev_addr = mem_req_addr;
            if (done_cyc < 0) begin
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        mem_req_ready = 1'b0;
        check(md ? "R4" : "R3", seq_bad == 0 && n_acc == exp_n, 32'(n_acc), 32'(exp_n),
              "request order/count/data");
        check("R2", seq_bad == 0, 32'(seq_bad), 0, "address sequence");
        check("R5", stall_bad == 0, 32'(stall_bad), 0, "stall hold");
        if (cnt == 0) check("R8", done_cyc == 0 && n_acc == 0, 32'(done_cyc), 0, "zero count done");
        else check("R7", done_cyc == last_acc + 1, 32'(done_cyc), 32'(last_acc + 1), "done timing");
        check("R6", acc_out === ea, acc_out, ea, "accumulator result");
        if (disturb) check("R9", acc_out === ea && n_acc == exp_n, acc_out, ea, "cfg/start ignored");
        @(negedge clk); #1;
        check("R7", done === 1'b0 && busy === 1'b0, 32'(done), 0, "done single pulse");
        hold = acc_out;
        repeat (3) @(negedge clk);
        #1;
        check("R6", acc_out === hold && acc_out === ea, acc_out, ea, "accumulator hold");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check("R1", mem_req_valid === 1'b0, 32'(mem_req_valid), 0, "reset valid");
        check("R1", done === 1'b0, 32'(done), 0, "reset done");
        check("R1", busy === 1'b0, 32'(busy), 0, "reset busy");
        check("R1", acc_out === 32'd0, acc_out, 0, "reset acc");
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1", mem_req_valid === 1'b0 && acc_out === 0, acc_out, 0, "idle after reset");

        run_loop(32'h0000_1000, 16'd4, 16'd256, 1'b0, 32'd2, 100, 1'b0);
        run_loop(32'h0000_2000, 16'd4, 16'd256, 1'b0, 32'd2, 40, 1'b0);
        run_loop(32'h0000_3000, 16'd8, 16'd0, 1'b1, 32'd5, 50, 1'b0);
        run_loop(32'h0000_4000, 16'd8, 16'd1, 1'b0, 32'd9, 50, 1'b0);
        run_loop(32'h0000_4000, 16'd8, 16'd1, 1'b1, 32'd9, 50, 1'b0);
        run_loop(32'h0001_0000, 16'hFFF0, 16'd20, 1'b1, 32'h1234_5678, 70, 1'b0);
        run_loop(32'hFFFF_FFF0, 16'd8, 16'd6, 1'b0, 32'd3, 60, 1'b0);
        run_loop(32'h0000_5000, 16'd0, 16'd5, 1'b1, 32'hFFFF_FFFF, 30, 1'b0);
        run_loop(32'h0000_6000, 16'd12, 16'd10, 1'b1, 32'd11, 50, 1'b1);
        run_loop(32'h0000_7000, 16'hFFFC, 16'd10, 1'b0, 32'd13, 80, 1'b1);
        for (int r = 0; r < 8; r++) begin
            run_loop($urandom, 16'($urandom), 16'(1 + $urandom % 40), 1'($urandom),
                     $urandom, 20 + int'($urandom % 81), 1'b0);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule